// File: doc/BRIEF.md
# Synchronous Serial Frame Transmitter

This block sends frames to external power switches or other peripherals over a one-way synchronous link. It drives a shift clock, one data line and three active-low enable lines. A frame starts on a software pulse, on a timer trigger, or continuously in a free-running mode. A pending command frame always goes out before the next data frame. When a data frame is due but no payload is ready, a passive frame fills the slot instead.

Each payload bit of a data frame comes either from an internal data word or from one of two alternate half-width buses. A per-bit select chooses the source. An emergency-stop input replaces chosen bits with preset values. A selection bit can be placed in front of the payload to mark command or data content. The baud generator lives outside this block. The block advances only on a clock-enable tick, and each bit takes two ticks: the clock rises on the first and falls on the second. A one-cycle done pulse, tagged with the frame kind, marks the end of every frame.

Top module: `sframe_tx`

## Requirements
- R1: While reset is asserted and after its release: sclk is low, sdo is low, en_n is 3'b111 and done is low.
- R2: Each bit takes two ticks. sclk rises on the first tick, and sdo changes on that same tick. sclk falls on the second tick, and sdo holds its value. Bits go out LSB first.
- R3: When sel_en is 1 on the start tick, the first bit is a selection bit: 1 for a command frame, 0 for a data or passive frame. When sel_en is 0, the payload starts at once.
- R4: Data payload bit i is alt bit i when src_sel[i]=1, and data_reg[i] otherwise. Here alt is {alt_hi, alt_lo}. All of these inputs are sampled on the start tick.
- R5: When emg_stop is 1 on the start tick of a data frame, every payload bit i with emg_mask[i]=1 carries emg_val[i] instead of its selected source.
- R6: Data frames use two enables. en_n = 3'b110 during the selection bit and payload bits 0 to DW/2-1. en_n = 3'b101 during the upper payload half. Command frames hold en_n = 3'b011 for every bit. en_n = 3'b111 during passive frames and whenever no frame is shifting. At most one enable is ever active.
- R7: A data-frame start while dat_ready=0 sends a passive frame. It has the same bit count as a data frame, sdo stays low and en_n stays 3'b111.
- R8: start_mode picks the data-frame trigger: 0 is sw_start, 1 is tmr_trig, 2 is free-running. A trigger that does not belong to the current mode is discarded and never starts a frame.
- R9: After the falling edge of a frame's last bit, sclk stays low and en_n stays 3'b111 for at least two ticks before the next frame begins.
- R10: done pulses for exactly one cycle, on the tick of the last bit's falling edge. done_kind gives the frame kind: 0 data, 1 command, 2 passive. Command frames carry CW bits after the optional selection bit, and data and passive frames carry DW bits.
- R11: When a command request and a data trigger are both pending on a start tick, the command frame goes first and the data frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | Clock-enable tick from the baud generator |
| start_mode | input | 2 | 0 software, 1 timer, 2 free-running |
| sw_start | input | 1 | Software start pulse |
| tmr_trig | input | 1 | Timer start pulse |
| cmd_req | input | 1 | Command frame request pulse |
| cmd_word | input | CW | Command payload, sampled at frame start |
| dat_ready | input | 1 | Payload valid; when 0 a passive frame is sent |
| sel_en | input | 1 | Prepend the selection bit |
| data_reg | input | DW | Internal data word |
| src_sel | input | DW | Per-bit source select (1 = alternate bus) |
| alt_lo | input | DW/2 | Alternate bus, lower payload half |
| alt_hi | input | DW/2 | Alternate bus, upper payload half |
| emg_stop | input | 1 | Emergency stop |
| emg_mask | input | DW | Bits overridden during emergency |
| emg_val | input | DW | Emergency bit values |
| sclk | output | 1 | Serial shift clock |
| sdo | output | 1 | Serial data |
| en_n | output | 3 | Active-low enables: [0] low half, [1] high half, [2] command |
| done | output | 1 | One-cycle end-of-frame pulse |
| done_kind | output | 2 | Kind of the frame just finished |

## Verification
A bit counter or shift register that drifts shows up on the data line or the enable pattern at the very next rising edge of sclk. It also shows up at the end of the frame as a done pulse that arrives with the wrong number of bits or on a cycle without a falling edge. A corrupted pending flag or start arbitration appears as a frame of the wrong kind, a frame out of order, or a frame after a discarded trigger. It becomes visible on the first clock edge of that frame, or as a missing done pulse within one frame time. A sequencer stuck in the gap or shifting state breaks the minimum idle spacing. That shows at the next frame start, or the bench watchdog catches it.

// File: rtl/sframe_pkg.sv
package sframe_pkg;
  typedef enum logic [1:0] {FK_DATA = 2'd0, FK_CMD = 2'd1, FK_PAS = 2'd2} frame_kind_t;
  typedef enum logic [1:0] {SM_SOFT = 2'd0, SM_TIMER = 2'd1, SM_FREE = 2'd2} start_mode_t;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_SHIFT = 2'd1, ST_GAP = 2'd2} seq_state_t;

  // value of one payload bit after source choice and emergency override
  function automatic logic pick_bit(logic use_alt, logic alt_b, logic reg_b,
                                    logic emg_on, logic emg_b);
    return emg_on ? emg_b : (use_alt ? alt_b : reg_b);
  endfunction

  // active-low enable pattern for bit position idx of a frame
  function automatic logic [2:0] en_pattern(frame_kind_t k, int idx, logic sel_on, int half);
    int pay;
    if (k == FK_CMD) return 3'b011;
    if (k == FK_PAS) return 3'b111;
    if (sel_on && idx == 0) return 3'b110;
    pay = sel_on ? idx - 1 : idx;
    return (pay < half) ? 3'b110 : 3'b101;
  endfunction
endpackage

// File: rtl/sframe_src.sv
module sframe_src
  import sframe_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0]   data_reg,
  input  logic [DW-1:0]   src_sel,
  input  logic [DW/2-1:0] alt_lo,
  input  logic [DW/2-1:0] alt_hi,
  input  logic            emg_stop,
  input  logic [DW-1:0]   emg_mask,
  input  logic [DW-1:0]   emg_val,
  output logic [DW-1:0]   payload
);
  localparam int HALF = DW / 2;
  logic [DW-1:0] alt_all;
  assign alt_all = {alt_hi, alt_lo};

  for (genvar i = 0; i < DW; i++) begin : g_bit
    assign payload[i] = pick_bit(src_sel[i], alt_all[i], data_reg[i],
                                 emg_stop & emg_mask[i], emg_val[i]);
  end

  // R4: half-buses must tile the payload exactly
  initial begin
    half_width_chk: assert (2 * HALF == DW);
  end
endmodule

// File: rtl/sframe_trig.sv
module sframe_trig
  import sframe_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  start_mode,
  input  logic        sw_start,
  input  logic        tmr_trig,
  input  logic        cmd_req,
  input  logic        dat_ready,
  input  logic        take,
  output logic        go,
  output frame_kind_t go_kind
);
  logic cmd_pend, sw_pend, tmr_pend, data_trig;

  always_comb begin
    unique case (start_mode)
      SM_SOFT:  data_trig = sw_pend;
      SM_TIMER: data_trig = tmr_pend;
      SM_FREE:  data_trig = 1'b1;
      default:  data_trig = 1'b0;
    endcase
  end

  assign go      = take & (cmd_pend | data_trig);
  assign go_kind = cmd_pend ? FK_CMD : (dat_ready ? FK_DATA : FK_PAS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_pend <= 1'b0;
      sw_pend  <= 1'b0;
      tmr_pend <= 1'b0;
    end else begin
      if (cmd_req) cmd_pend <= 1'b1;
      else if (go && cmd_pend) cmd_pend <= 1'b0;
      if (sw_start && start_mode == SM_SOFT) sw_pend <= 1'b1;
      else if (go && !cmd_pend) sw_pend <= 1'b0;
      if (tmr_trig && start_mode == SM_TIMER) tmr_pend <= 1'b1;
      else if (go && !cmd_pend) tmr_pend <= 1'b0;
    end
  end

  // R11
  cmd_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && $past(cmd_req)) |-> go_kind == FK_CMD);
endmodule

// File: rtl/sframe_tx.sv
module sframe_tx
  import sframe_pkg::*;
#(
  parameter int DW = 16,
  parameter int CW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bit_tick,
  input  logic [1:0]      start_mode,
  input  logic            sw_start,
  input  logic            tmr_trig,
  input  logic            cmd_req,
  input  logic [CW-1:0]   cmd_word,
  input  logic            dat_ready,
  input  logic            sel_en,
  input  logic [DW-1:0]   data_reg,
  input  logic [DW-1:0]   src_sel,
  input  logic [DW/2-1:0] alt_lo,
  input  logic [DW/2-1:0] alt_hi,
  input  logic            emg_stop,
  input  logic [DW-1:0]   emg_mask,
  input  logic [DW-1:0]   emg_val,
  output logic            sclk,
  output logic            sdo,
  output logic [2:0]      en_n,
  output logic            done,
  output logic [1:0]      done_kind
);
  localparam int MAXW = (DW > CW) ? DW : CW;
  localparam int FW   = MAXW + 1;
  localparam int PW   = $clog2(FW + 1);

  seq_state_t    state;
  frame_kind_t   kind_q, go_kind;
  logic          go, take, busy, sel_q, gap_q;
  logic          sclk_q, sdo_q, done_q;
  logic [2:0]    en_q;
  logic [FW-1:0] shreg, new_frame;
  logic [PW-1:0] pos, len_q, new_len;
  logic [MAXW-1:0] body;
  logic [DW-1:0] payload;

  sframe_src #(.DW(DW)) u_src (
    .data_reg(data_reg), .src_sel(src_sel), .alt_lo(alt_lo), .alt_hi(alt_hi),
    .emg_stop(emg_stop), .emg_mask(emg_mask), .emg_val(emg_val), .payload(payload)
  );

  assign take = bit_tick && state == ST_IDLE;
  assign busy = state == ST_SHIFT;

  sframe_trig u_trig (
    .clk(clk), .rst_n(rst_n), .start_mode(start_mode), .sw_start(sw_start),
    .tmr_trig(tmr_trig), .cmd_req(cmd_req), .dat_ready(dat_ready),
    .take(take), .go(go), .go_kind(go_kind)
  );

  always_comb begin
    body = '0;
    if (go_kind == FK_CMD) body[CW-1:0] = cmd_word;
    else if (go_kind == FK_DATA) body[DW-1:0] = payload;
    new_frame = sel_en ? {body, go_kind == FK_CMD} : {1'b0, body};
    new_len   = ((go_kind == FK_CMD) ? PW'(CW) : PW'(DW)) + {{(PW-1){1'b0}}, sel_en};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      kind_q <= FK_DATA;
      sel_q  <= 1'b0;
      gap_q  <= 1'b0;
      sclk_q <= 1'b0;
      sdo_q  <= 1'b0;
      done_q <= 1'b0;
      en_q   <= 3'b111;
      shreg  <= '0;
      pos    <= '0;
      len_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (bit_tick) begin
        unique case (state)
          ST_IDLE: if (go) begin
            state  <= ST_SHIFT;
            kind_q <= go_kind;
            sel_q  <= sel_en;
            len_q  <= new_len;
            sdo_q  <= new_frame[0];
            shreg  <= new_frame >> 1;
            pos    <= '0;
            sclk_q <= 1'b1;
            en_q   <= en_pattern(go_kind, 0, sel_en, DW / 2);
          end
          ST_SHIFT: if (sclk_q) begin
            sclk_q <= 1'b0;
            if (pos == len_q - 1'b1) begin
              state  <= ST_GAP;
              en_q   <= 3'b111;
              done_q <= 1'b1;
              gap_q  <= 1'b0;
            end
          end else begin
            sclk_q <= 1'b1;
            sdo_q  <= shreg[0];
            shreg  <= shreg >> 1;
            pos    <= pos + 1'b1;
            en_q   <= en_pattern(kind_q, int'(pos) + 1, sel_q, DW / 2);
          end
          ST_GAP: if (gap_q) state <= ST_IDLE;
                  else gap_q <= 1'b1;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign sclk      = sclk_q;
  assign sdo       = sdo_q;
  assign en_n      = en_q;
  assign done      = done_q;
  assign done_kind = kind_q;

  // R6
  en_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> en_q == 3'b111);
  // R6
  en_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~en_q));
  // R2
  sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk_q) |-> $stable(sdo_q));
  // R9
  gap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_GAP |-> !sclk_q && en_q == 3'b111);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R10
  done_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $fell(sclk_q));
endmodule

// File: tb/sframe_tx_bench.sv
module sframe_tx_bench;
  localparam int DW = 16;
  localparam int CW = 16;

  logic clk = 1'b0, rst_n = 1'b0, bit_tick = 1'b0;
  logic [1:0] start_mode = 2'd0;
  logic sw_start = 0, tmr_trig = 0, cmd_req = 0, dat_ready = 1, sel_en = 1, emg_stop = 0;
  logic [CW-1:0] cmd_word = '0;
  logic [DW-1:0] data_reg = '0, src_sel = '0, emg_mask = '0, emg_val = '0;
  logic [DW/2-1:0] alt_lo = '0, alt_hi = '0;
  logic sclk, sdo, done;
  logic [2:0] en_n;
  logic [1:0] done_kind;

  sframe_tx #(.DW(DW), .CW(CW)) u_sframe_tx (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .start_mode(start_mode),
    .sw_start(sw_start), .tmr_trig(tmr_trig), .cmd_req(cmd_req), .cmd_word(cmd_word),
    .dat_ready(dat_ready), .sel_en(sel_en), .data_reg(data_reg), .src_sel(src_sel),
    .alt_lo(alt_lo), .alt_hi(alt_hi), .emg_stop(emg_stop), .emg_mask(emg_mask),
    .emg_val(emg_val), .sclk(sclk), .sdo(sdo), .en_n(en_n), .done(done),
    .done_kind(done_kind)
  );

  always #2 clk = ~clk;

  int n_vec = 0, n_fail = 0;
  logic [3:0] exp_q[$];
  logic [1:0] kind_q[$];
  int nb_q[$];
  int done_log[64];
  int done_n = 0, rise_n = 0, bits_in = 0, hi_cnt = 0, gap_cyc = 0;
  logic sclk_prev = 0, in_gap = 0, gap_bad = 0, finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_payload();
    logic [DW-1:0] p;
    p = ({alt_hi, alt_lo} & src_sel) | (data_reg & ~src_sel);
    if (emg_stop) p = (emg_val & emg_mask) | (p & ~emg_mask);
    return p;
  endfunction

  // scoreboard driver side: queue every expected bit with its enable pattern
  task automatic push_frame(input logic [1:0] k, input logic [15:0] body, input logic s);
    int n;
    logic [2:0] e;
    n = (k == 2'd1) ? CW : DW;
    if (s) begin
      e = (k == 2'd1) ? 3'b011 : (k == 2'd2) ? 3'b111 : 3'b110;
      exp_q.push_back({k == 2'd1, e});
    end
    for (int i = 0; i < n; i++) begin
      e = (k == 2'd1) ? 3'b011 : (k == 2'd2) ? 3'b111 : ((i < DW / 2) ? 3'b110 : 3'b101);
      exp_q.push_back({(k == 2'd2) ? 1'b0 : body[i], e});
    end
    kind_q.push_back(k);
    nb_q.push_back(n + (s ? 1 : 0));
  endtask

  always @(negedge clk) begin
    if (!rst_n) bit_tick <= 1'b0;
    else bit_tick <= ~bit_tick;
  end

  // monitor
  always @(negedge clk) begin
    logic [3:0] e;
    if (rst_n) begin
      if (sclk && !sclk_prev) begin
        rise_n++;
        bits_in++;
        if (in_gap) begin
          chk(gap_cyc >= 4 && !gap_bad, "R9", "idle gap cycles", gap_cyc, 4);
          in_gap = 0;
        end
        if (exp_q.size() == 0) chk(0, "R8", "unexpected bit", 1, 0);
        else begin
          e = exp_q.pop_front();
          chk(sdo == e[3], "R4", "sdo bit", sdo, e[3]);
          chk(en_n == e[2:0], "R6", "enables", en_n, e[2:0]);
        end
      end else if (in_gap) begin
        gap_cyc++;
        if (sclk || en_n != 3'b111) gap_bad = 1;
      end
      if (sclk) hi_cnt++;
      if (!sclk && sclk_prev) begin
        chk(hi_cnt == 2, "R2", "sclk high cycles", hi_cnt, 2);
        hi_cnt = 0;
      end
      if (done) begin
        chk(sclk_prev && !sclk, "R10", "done on fall", sclk_prev, 1);
        if (kind_q.size() == 0) chk(0, "R10", "unexpected done", 1, 0);
        else begin
          chk(done_kind == kind_q[0], "R10", "done kind", done_kind, kind_q[0]);
          chk(bits_in == nb_q[0], "R10", "frame length", bits_in, nb_q[0]);
          void'(kind_q.pop_front());
          void'(nb_q.pop_front());
        end
        if (done_n < 64) done_log[done_n] = done_kind;
        done_n++;
        bits_in = 0;
        in_gap = 1; gap_cyc = 0; gap_bad = 0;
      end
      sclk_prev = sclk;
    end
  end

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) sw_start = 1; else if (which == 1) tmr_trig = 1; else cmd_req = 1;
    @(negedge clk);
    sw_start = 0; tmr_trig = 0; cmd_req = 0;
  endtask

  task automatic wait_idle();
    while (kind_q.size() != 0) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "R10", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int r0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(sclk == 0 && sdo == 0, "R1", "sclk/sdo in reset", {sclk, sdo}, 0);
    chk(en_n == 3'b111 && done == 0, "R1", "en/done in reset", {en_n, done}, 4'b1110);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(sclk == 0 && en_n == 3'b111, "R1", "idle after reset", {sclk, en_n}, 4'b0111);

    // R2 R3 plain data frame, register source, selection bit on
    data_reg = 16'hA5C3;
    push_frame(2'd0, exp_payload(), 1'b1);
    pulse(0); wait_idle();

    // R4 mixed sources
    src_sel = 16'hF00F; alt_lo = 8'h3C; alt_hi = 8'h96; data_reg = 16'h0FF0;
    push_frame(2'd0, exp_payload(), 1'b1);
    pulse(0); wait_idle();

    // R3 no selection bit
    sel_en = 0; src_sel = '0; data_reg = 16'h8001;
    push_frame(2'd0, exp_payload(), 1'b0);
    pulse(0); wait_idle();
    sel_en = 1;

    // R5 emergency override
    emg_stop = 1; emg_mask = 16'h00FF; emg_val = 16'hFF5A; data_reg = 16'h1234;
    src_sel = 16'h0100; alt_hi = 8'hFE;
    push_frame(2'd0, exp_payload(), 1'b1);
    pulse(0); wait_idle();
    emg_stop = 0; src_sel = '0;

    // R3 R6 command frame
    cmd_word = 16'h4B1D;
    push_frame(2'd1, cmd_word, 1'b1);
    pulse(2); wait_idle();

    // R7 passive frame
    dat_ready = 0;
    push_frame(2'd2, 16'h0, 1'b1);
    pulse(0); wait_idle();
    dat_ready = 1;

    // R8 timer mode discards software start
    start_mode = 2'd1;
    r0 = rise_n;
    pulse(0);
    repeat (60) @(negedge clk);
    chk(rise_n == r0, "R8", "sw_start in timer mode", rise_n - r0, 0);
    data_reg = 16'h5AA5;
    push_frame(2'd0, exp_payload(), 1'b1);
    pulse(1); wait_idle();
    start_mode = 2'd0;

    // R8 software mode discards timer trigger
    r0 = rise_n;
    pulse(1);
    repeat (60) @(negedge clk);
    chk(rise_n == r0, "R8", "tmr_trig in soft mode", rise_n - r0, 0);

    // R11 command and data pending together
    cmd_word = 16'hC0DE; data_reg = 16'h7E81;
    push_frame(2'd1, cmd_word, 1'b1);
    push_frame(2'd0, exp_payload(), 1'b1);
    @(negedge clk); cmd_req = 1; sw_start = 1;
    @(negedge clk); cmd_req = 0; sw_start = 0;
    wait_idle();
    chk(done_log[done_n-2] == 1 && done_log[done_n-1] == 0, "R11", "frame order",
        {done_log[done_n-2][1:0], done_log[done_n-1][1:0]}, 4'b0100);

    // R8 free-running: two back-to-back frames
    data_reg = 16'h3C3C;
    r0 = done_n;
    push_frame(2'd0, exp_payload(), 1'b1);
    push_frame(2'd0, exp_payload(), 1'b1);
    @(negedge clk); start_mode = 2'd2;
    while (done_n < r0 + 2) @(negedge clk);
    start_mode = 2'd0;
    r0 = rise_n;
    repeat (60) @(negedge clk);
    chk(rise_n == r0, "R8", "free-run stops on mode change", rise_n - r0, 0);
    chk(exp_q.size() == 0, "R10", "bits left in scoreboard", exp_q.size(), 0);

    finish_run();
  end
endmodule